// File: doc/BRIEF.md
# Sample Status and Interrupt Router

This block sits beside the sample path and the motion detector of a three-axis motion sensor. It keeps two status flags for the host: one says a fresh sample is waiting, the other says a sample was lost. The sample path pulses a strobe each time it stores a new sample. The host interface pulses an acknowledge when the sample has been read.

The detector reports level events and pulse events for each axis, plus a double-pulse event. A routing setting picks which event class feeds each of two sticky interrupt latches. The latched interrupts and the per-axis event sources appear in a detection-source byte. Two output pins carry the latched interrupts. The pins can be swapped, and pin 1 can be given over to the data-ready flag instead.

Software drives the block through a small write-only register bus. One location holds the routing setting. The other holds two hold-clear bits, one for each interrupt latch.

Top module: `sirq_router`

## Requirements
- R1: The data-ready flag (status bit 0) sets in the cycle after a new-sample strobe. It clears in the cycle after a read acknowledge that has no new-sample strobe beside it. When both strobes come in the same cycle, the flag ends up set.
- R2: The overrun flag (status bit 1) sets when a new-sample strobe arrives while data-ready is already set and no acknowledge comes in the same cycle. A read acknowledge clears it.
- R3: Status bit 2 follows the trim parity error input. Status bits above bit 2 read 0.
- R4: The pairing field (route register bits 1:0) sets what feeds each interrupt signal:
  - 0: signal 1 takes any level event and signal 2 takes any pulse event.
  - 1: signal 1 takes pulse and signal 2 takes level.
  - 2: signal 1 takes any pulse event and signal 2 takes the double-pulse event.
  - 3: behaves like 0.
- R5: An interrupt latch sets one cycle after its event and stays set. While its hold-clear bit is 1, the latch is forced to 0 and ignores events. Writing that bit back to 0 re-enables the latch.
- R6: The detection-source byte is laid out, from bit 0 upward, as: signal 1, signal 2, pulse Z, pulse Y, pulse X, level Z, level Y, level X.
  - The axis bits are sticky. In the event inputs, index 0 is Z, index 1 is Y and index 2 is X.
  - Level axis bits are held clear by the hold-clear bit of the latch that level feeds. Under pairing 2, level feeds no latch, so they are always held clear.
  - Pulse axis bits are held clear by the hold-clear bit of the latch that single pulse feeds.
- R7: With the swap bit (route bit 2) at 0, signal 1 drives pin 1 and signal 2 drives pin 2. With the swap bit at 1, the two are exchanged.
- R8: With the data-ready-to-pin bit (route bit 3) set, pin 1 shows the data-ready flag in place of its interrupt signal. Pin 2 is unaffected.
- R9: Synchronous reset clears both flags, both latches, all axis bits, the route register and the hold-clear bits.
- R10: A write to address 0 loads the route register from data bits 3:0, and data bits 7:4 are ignored. A write to address 1 loads the hold-clear bits from data bits 1:0, bit 0 for signal 1. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_new_i | input | 1 | New sample stored strobe |
| sample_ack_i | input | 1 | Sample read acknowledge strobe |
| trim_err_i | input | 1 | Trim parity error level |
| lvl_evt_i | input | NAXIS | Level event strobes per axis (0 = Z) |
| pls_evt_i | input | NAXIS | Pulse event strobes per axis (0 = Z) |
| dbl_evt_i | input | 1 | Double-pulse event strobe |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | AW | Register address |
| cfg_wdata_i | input | DW | Register write data |
| status_o | output | DW | Status byte |
| src_o | output | 2*NAXIS+2 | Detection-source byte |
| irq_pin1_o | output | 1 | Interrupt pin 1 |
| irq_pin2_o | output | 1 | Interrupt pin 2 |

## Verification
The routing function is driven with single-class events under every pairing value, with swap on and off and with the data-ready override on. Each pattern shows which signal an event class reaches and which pin that signal lands on. Level-only events under the single/double pairing show that level is dropped there. Pairing 3 is exercised to show it matches pairing 0. Mixed level and pulse events followed by clearing only one latch separate which axis bits belong to which hold-clear bit. The sample flags are driven with back-to-back strobes and same-cycle strobe and acknowledge, which separates overrun from plain readiness.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        PAIR_LVL_PLS = 2'd0,
        PAIR_PLS_LVL = 2'd1,
        PAIR_SGL_DBL = 2'd2,
        PAIR_RSVD    = 2'd3
    } pair_e;

    typedef struct packed {
        logic  drdy_pin;
        logic  swap;
        pair_e pair;
    } route_cfg_t;

    localparam int ADDR_ROUTE = 0;
    localparam int ADDR_CLEAR = 1;
    localparam int ROUTE_W    = $bits(route_cfg_t);

    // returns {signal2 event, signal1 event}
    function automatic logic [1:0] pair_events(pair_e p, logic lvl, logic pls, logic dbl);
        case (p)
            PAIR_PLS_LVL: pair_events = {lvl, pls};
            PAIR_SGL_DBL: pair_events = {dbl, pls};
            default:      pair_events = {pls, lvl};
        endcase
    endfunction

    function automatic logic lvl_hold(pair_e p, logic [1:0] hold);
        case (p)
            PAIR_PLS_LVL: lvl_hold = hold[1];
            PAIR_SGL_DBL: lvl_hold = 1'b1;
            default:      lvl_hold = hold[0];
        endcase
    endfunction

    function automatic logic pls_hold(pair_e p, logic [1:0] hold);
        case (p)
            PAIR_PLS_LVL, PAIR_SGL_DBL: pls_hold = hold[0];
            default:                    pls_hold = hold[1];
        endcase
    endfunction

endpackage

// File: rtl/sirq_cfg_regs.sv
module sirq_cfg_regs
    import sirq_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output route_cfg_t    route_o,
    output logic [1:0]    hold_o
);
    route_cfg_t route_q;
    logic [1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            hold_q  <= '0;
        end else if (we_i) begin
            if (addr_i == AW'(ADDR_ROUTE))
                route_q <= route_cfg_t'(wdata_i[ROUTE_W-1:0]);
            if (addr_i == AW'(ADDR_CLEAR))
                hold_q <= wdata_i[1:0];
        end
    end

    assign route_o = route_q;
    assign hold_o  = hold_q;

    // R10: writes elsewhere leave both registers alone
    a_r10_other_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (!we_i || (addr_i != AW'(ADDR_ROUTE) && addr_i != AW'(ADDR_CLEAR)))
        |=> ($stable(route_q) && $stable(hold_q)));
endmodule

// File: rtl/sirq_ready_track.sv
module sirq_ready_track (
    input  logic clk,
    input  logic rst,
    input  logic new_i,
    input  logic ack_i,
    output logic drdy_o,
    output logic ovr_o
);
    logic drdy_q, ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drdy_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (new_i)      drdy_q <= 1'b1;
            else if (ack_i) drdy_q <= 1'b0;

            if (new_i && drdy_q && !ack_i) ovr_q <= 1'b1;
            else if (ack_i)                ovr_q <= 1'b0;
        end
    end

    assign drdy_o = drdy_q;
    assign ovr_o  = ovr_q;

    a_r1_new_sets_ready: assert property (@(posedge clk) disable iff (rst)
        new_i |=> drdy_q);
    a_r1_ack_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !new_i) |=> (!drdy_q && !ovr_q));
    a_r2_overrun_needs_ready: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> drdy_q);
    a_r2_ack_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !ovr_q);
endmodule

// File: rtl/sirq_sticky.sv
module sirq_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || hold_i) q <= '0;
        else               q <= q | set_i;
    end

    assign q_o = q;

    a_r5_hold_forces_clear: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (q == '0));
    a_r5_bits_stay_set: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> ((q & $past(q)) == $past(q)));
    a_r6_event_captured: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/sirq_router.sv
module sirq_router
    import sirq_pkg::*;
#(
    parameter int NAXIS = 3,
    parameter int AW    = 2,
    parameter int DW    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_new_i,
    input  logic               sample_ack_i,
    input  logic               trim_err_i,
    input  logic [NAXIS-1:0]   lvl_evt_i,
    input  logic [NAXIS-1:0]   pls_evt_i,
    input  logic               dbl_evt_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [DW-1:0]      cfg_wdata_i,
    output logic [DW-1:0]      status_o,
    output logic [2*NAXIS+1:0] src_o,
    output logic               irq_pin1_o,
    output logic               irq_pin2_o
);
    localparam int STAT_PAD = DW - 3;

    route_cfg_t       route;
    logic [1:0]       hold;
    logic             drdy, ovr;
    logic [1:0]       ev;
    logic [1:0]       irq_q;
    logic [NAXIS-1:0] lvl_q, pls_q;
    logic             sig_p1, sig_p2;

    sirq_cfg_regs #(.AW(AW), .DW(DW)) regs_i (
        .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .route_o(route), .hold_o(hold)
    );

    sirq_ready_track ready_i (
        .clk(clk), .rst(rst), .new_i(sample_new_i), .ack_i(sample_ack_i),
        .drdy_o(drdy), .ovr_o(ovr)
    );

    assign ev = pair_events(route.pair, |lvl_evt_i, |pls_evt_i, dbl_evt_i);

    for (genvar g = 0; g < 2; g++) begin : g_irq
        sirq_sticky #(.W(1)) latch_i (
            .clk(clk), .rst(rst), .hold_i(hold[g]),
            .set_i(ev[g]), .q_o(irq_q[g])
        );
    end

    sirq_sticky #(.W(NAXIS)) lvl_src_i (
        .clk(clk), .rst(rst), .hold_i(lvl_hold(route.pair, hold)),
        .set_i(lvl_evt_i), .q_o(lvl_q)
    );

    sirq_sticky #(.W(NAXIS)) pls_src_i (
        .clk(clk), .rst(rst), .hold_i(pls_hold(route.pair, hold)),
        .set_i(pls_evt_i), .q_o(pls_q)
    );

    always_comb begin
        sig_p1     = route.swap ? irq_q[1] : irq_q[0];
        sig_p2     = route.swap ? irq_q[0] : irq_q[1];
        irq_pin1_o = route.drdy_pin ? drdy : sig_p1;
        irq_pin2_o = sig_p2;
    end

    assign status_o = {{STAT_PAD{1'b0}}, trim_err_i, ovr, drdy};
    assign src_o    = {lvl_q, pls_q, irq_q[1], irq_q[0]};

    // R7: pin 2 always carries one of the two latches
    a_r7_pin2_from_latch: assert property (@(posedge clk) disable iff (rst)
        irq_pin2_o |-> (irq_q != 2'b00));
    // R4: no pairing routes level to a latch under single/double
    a_r4_sgl_dbl_drops_level: assert property (@(posedge clk) disable iff (rst)
        (route.pair == PAIR_SGL_DBL && $stable(route) && hold == 2'b00 && lvl_q == '0)
        |=> (lvl_q == '0));
endmodule

// File: tb/sirq_router_tb_top.sv
module sirq_router_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       sample_new_i, sample_ack_i, trim_err_i, dbl_evt_i, cfg_we_i;
    logic [2:0] lvl_evt_i, pls_evt_i;
    logic [1:0] cfg_addr_i;
    logic [7:0] cfg_wdata_i;
    logic [7:0] status_o, src_o;
    logic       irq_pin1_o, irq_pin2_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sirq_router dut_i (
        .clk(clk), .rst(rst), .sample_new_i(sample_new_i), .sample_ack_i(sample_ack_i),
        .trim_err_i(trim_err_i), .lvl_evt_i(lvl_evt_i), .pls_evt_i(pls_evt_i),
        .dbl_evt_i(dbl_evt_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .status_o(status_o), .src_o(src_o),
        .irq_pin1_o(irq_pin1_o), .irq_pin2_o(irq_pin2_o)
    );

    // {route byte, lvl, pls, dbl, {pin2,pin1}, source byte}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {8'h00, 3'b001, 3'b000, 1'b0, 2'b01, 8'h21},
        {8'h00, 3'b000, 3'b010, 1'b0, 2'b10, 8'h0A},
        {8'h01, 3'b100, 3'b000, 1'b0, 2'b10, 8'h82},
        {8'h01, 3'b000, 3'b001, 1'b0, 2'b01, 8'h05},
        {8'h02, 3'b000, 3'b000, 1'b1, 2'b10, 8'h02},
        {8'h02, 3'b111, 3'b000, 1'b0, 2'b00, 8'h00},
        {8'h02, 3'b000, 3'b100, 1'b0, 2'b01, 8'h11},
        {8'h03, 3'b010, 3'b000, 1'b0, 2'b01, 8'h41},
        {8'h04, 3'b001, 3'b000, 1'b0, 2'b10, 8'h21},
        {8'h05, 3'b001, 3'b000, 1'b0, 2'b01, 8'h22},
        {8'h08, 3'b001, 3'b000, 1'b0, 2'b00, 8'h21},
        {8'h0C, 3'b000, 3'b001, 1'b0, 2'b00, 8'h06}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        tick();
        cfg_we_i = 1'b0;
    endtask

    task automatic events(logic [2:0] l, logic [2:0] p, logic d);
        lvl_evt_i = l; pls_evt_i = p; dbl_evt_i = d;
        tick();
        lvl_evt_i = '0; pls_evt_i = '0; dbl_evt_i = 1'b0;
    endtask

    task automatic clear_all();
        wr(2'd1, 8'h03);
        wr(2'd1, 8'h00);
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sample_new_i = 0; sample_ack_i = 0; trim_err_i = 0;
        lvl_evt_i = '0; pls_evt_i = '0; dbl_evt_i = 0;
        cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0;
        tick(); tick();
        rst = 1'b0;
        // R9 reset state
        chk("R9 status", status_o, 8'h00);
        chk("R9 source", src_o, 8'h00);
        chk("R9 pins", {irq_pin2_o, irq_pin1_o}, 2'b00);

        // table: R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i][24:17]);
            clear_all();
            events(VEC[i][16:14], VEC[i][13:11], VEC[i][10]);
            chk($sformatf("R4/R7/R8 pins vec%0d", i), {irq_pin2_o, irq_pin1_o}, VEC[i][9:8]);
            chk($sformatf("R4/R6 source vec%0d", i), src_o, VEC[i][7:0]);
        end

        // R1 / R2 sample flags
        wr(2'd0, 8'h00);
        clear_all();
        sample_new_i = 1; tick(); sample_new_i = 0;
        chk("R1 ready after new", status_o, 8'h01);
        sample_new_i = 1; tick(); sample_new_i = 0;
        chk("R2 overrun on second new", status_o, 8'h03);
        sample_ack_i = 1; tick(); sample_ack_i = 0;
        chk("R1 R2 ack clears", status_o, 8'h00);
        sample_new_i = 1; tick();
        sample_ack_i = 1; tick(); sample_new_i = 0; sample_ack_i = 0;
        chk("R1 new with ack keeps ready, R2 no overrun", status_o, 8'h01);
        sample_ack_i = 1; tick(); sample_ack_i = 0;
        chk("R1 ack alone clears", status_o, 8'h00);

        // R3 trim error
        trim_err_i = 1; #1;
        chk("R3 trim bit", status_o, 8'h04);
        trim_err_i = 0;

        // R5 hold-clear blocks, sticky afterwards
        wr(2'd1, 8'h01);
        events(3'b001, 3'b000, 1'b0);
        chk("R5 held latch ignores event", src_o, 8'h00);
        wr(2'd1, 8'h00);
        events(3'b001, 3'b000, 1'b0);
        tick(); tick(); tick();
        chk("R5 re-enabled latch sticky", src_o, 8'h21);

        // R6 selective clear under pairing 0
        clear_all();
        events(3'b010, 3'b100, 1'b0);
        chk("R6 mixed sources", src_o, 8'h53);
        wr(2'd1, 8'h01);
        tick();
        chk("R6 clear only signal 1 side", src_o, 8'h12);
        wr(2'd1, 8'h00);

        // R8 data-ready on pin 1
        wr(2'd0, 8'h08);
        sample_new_i = 1; tick(); sample_new_i = 0;
        chk("R8 pin1 shows ready, pin2 keeps signal 2", {irq_pin2_o, irq_pin1_o}, 2'b11);
        sample_ack_i = 1; tick(); sample_ack_i = 0;
        chk("R8 pin1 follows ready clear", irq_pin1_o, 1'b0);

        // R10 other addresses and upper data bits ignored
        wr(2'd0, 8'hF0);
        clear_all();
        wr(2'd2, 8'h07);
        wr(2'd3, 8'h07);
        events(3'b001, 3'b000, 1'b0);
        chk("R10 ignored writes", {irq_pin2_o, irq_pin1_o}, 2'b01);

        // R9 reset mid-run
        wr(2'd0, 8'h0F);
        sample_new_i = 1; tick(); sample_new_i = 0;
        rst = 1; tick(); tick(); rst = 0;
        chk("R9 reset clears status", status_o, 8'h00);
        chk("R9 reset clears source", src_o, 8'h00);
        events(3'b001, 3'b000, 1'b0);
        chk("R9 route back to default", {irq_pin2_o, irq_pin1_o}, 2'b01);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule